// File: doc/BRIEF.md
# Frame Length Bin Statistics Counters

This block keeps statistics counters that sort finished Ethernet frames by length. With the default parameters it has two bins: one for frames of exactly 64 bytes and one for frames of 65 to 127 bytes. The length is measured from the destination address through the FCS. The preamble and start delimiter are not counted. Each bin counts frames from the transmit side and the receive side together. It also counts good and bad frames alike, so the block takes no frame-status input. The MAC raises a one-cycle done strobe on either side, together with that frame's length.

Software reads the counters and two small control words through a register read port. A write port sets the per-bin carry masks and clears carry flags. A carry flag latches when its counter wraps. A single interrupt output is high while any carry flag is set and not masked. Two more controls are provided. A level input makes every counter read also zero that counter. A pulse input zeroes all counters and all carry flags at once.

Top module: `frame_size_stats`

## Requirements
- R1: A done strobe with a length of exactly 64 adds one to the 64-byte counter (read address 0). This holds on either the transmit or the receive side.
- R2: A done strobe with a length from 65 to 127 inclusive adds one to the 65–127 counter (read address 1). This holds on either side.
- R3: A length below 64 or above 127 changes neither counter.
- R4: When the transmit and receive strobes hit the same bin in one cycle, that counter grows by two.
- R5: A counter read returns the CNT_W-bit count in the top CNT_W bits of the REG_W-bit word. All lower bits read as zero. Read data is combinational from the current state for the address on rdAddr.
- R6: While clrOnRd is high, a read of a counter returns its old value. After that edge the counter holds only the increments from the read cycle. While clrOnRd is low, a read leaves the counter unchanged.
- R7: A clrAll pulse zeroes every counter and every carry flag at the next edge. It takes priority over increments and reads in the same cycle.
- R8: A counter that passes its all-ones value and wraps sets its carry flag. Bit b of read address 2 is the carry flag of bin b. Writing a 1 to that bit at address 2 clears the flag, but a wrap in the same cycle keeps it set. A flag stays set otherwise.
- R9: Bit b of address 3 is the mask of bin b. It is written and read at that address. irq is high exactly when some carry flag is set with its mask bit at 0.
- R10: Writes to counter addresses are ignored.
- R11: After reset all counters, carry flags and masks are zero, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txDone | input | 1 | Transmit frame finished this cycle |
| txLen | input | LEN_W | Transmit frame length in bytes, including FCS |
| rxDone | input | 1 | Receive frame finished this cycle |
| rxLen | input | LEN_W | Receive frame length in bytes, including FCS |
| clrOnRd | input | 1 | Counter reads also clear the counter |
| clrAll | input | 1 | Zero all counters and carry flags |
| rdEn | input | 1 | Register read this cycle |
| rdAddr | input | ADDR_W | Read address: bins, then carry, then mask |
| rdData | output | REG_W | Read data for rdAddr |
| wrEn | input | 1 | Register write this cycle |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | REG_W | Write data |
| irq | output | 1 | Unmasked carry pending |

## Verification
The assertions cover the cycle-by-cycle rules. A global clear leaves all counters and flags at zero on the next cycle. A counter never advances by more than two between clears. A carry flag only rises out of a near-full counter and only drops through a clear, and masks change only on a mask write. The bench scenarios cover the rest. These include the length decode at the bin edges, the coincident transmit and receive increment, clear-on-read returning the old value while keeping a same-cycle increment, a carry that survives its own clear in the wrap cycle, and the ignored counter writes.

// File: rtl/fss_pkg.sv
package fss_pkg;

  // Smallest frame length that lands in any bin.
  localparam int unsigned BASE_LEN = 64;

  // Bin 0 is exactly BASE_LEN; bin b > 0 spans (BASE_LEN<<(b-1))+1 .. (BASE_LEN<<b)-1.
  function automatic int unsigned binLo(int unsigned b);
    return (b == 0) ? BASE_LEN : (BASE_LEN << (b - 1)) + 1;
  endfunction

  function automatic int unsigned binHi(int unsigned b);
    return (b == 0) ? BASE_LEN : (BASE_LEN << b) - 1;
  endfunction

  // Strobes from control to datapath, one set per bin.
  typedef struct packed {
    logic hitTx;
    logic hitRx;
    logic rdClr;
    logic carryClr;
    logic maskWe;
    logic maskVal;
  } binStrobe_t;

endpackage

// File: rtl/fss_ctrl.sv
module fss_ctrl
  import fss_pkg::*;
#(
  parameter int unsigned NBIN   = 2,
  parameter int unsigned LEN_W  = 14,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned REG_W  = 32
) (
  input  logic                  txDone,
  input  logic [LEN_W-1:0]      txLen,
  input  logic                  rxDone,
  input  logic [LEN_W-1:0]      rxLen,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     rdAddr,
  input  logic                  clrOnRd,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [REG_W-1:0]      wrData,
  output binStrobe_t [NBIN-1:0] binStb
);

  localparam int unsigned CARRY_ADDR = NBIN;
  localparam int unsigned MASK_ADDR  = NBIN + 1;

  function automatic logic inBin(logic [LEN_W-1:0] len, int unsigned b);
    return (32'(len) >= binLo(b)) && (32'(len) <= binHi(b));
  endfunction

  logic carryWr;
  logic maskWr;

  always_comb begin
    carryWr = wrEn && (wrAddr == ADDR_W'(CARRY_ADDR));
    maskWr  = wrEn && (wrAddr == ADDR_W'(MASK_ADDR));
    binStb  = '0;
    for (int b = 0; b < NBIN; b++) begin
      binStb[b].hitTx    = txDone && inBin(txLen, b);
      binStb[b].hitRx    = rxDone && inBin(rxLen, b);
      binStb[b].rdClr    = rdEn && clrOnRd && (rdAddr == ADDR_W'(b));
      binStb[b].carryClr = carryWr && wrData[b];
      binStb[b].maskWe   = maskWr;
      binStb[b].maskVal  = wrData[b];
    end
  end

endmodule

// File: rtl/fss_datapath.sv
module fss_datapath
  import fss_pkg::*;
#(
  parameter int unsigned NBIN   = 2,
  parameter int unsigned CNT_W  = 22,
  parameter int unsigned REG_W  = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        clrAll,
  input  binStrobe_t [NBIN-1:0]       binStb,
  input  logic [ADDR_W-1:0]           rdAddr,
  output logic [REG_W-1:0]            rdData,
  output logic                        irq,
  output logic [NBIN-1:0][CNT_W-1:0]  cntVec,
  output logic [NBIN-1:0]             carryVec,
  output logic [NBIN-1:0]             maskVec
);

  localparam int unsigned PAD_W      = REG_W - CNT_W;
  localparam int unsigned CARRY_ADDR = NBIN;
  localparam int unsigned MASK_ADDR  = NBIN + 1;

  for (genvar b = 0; b < NBIN; b++) begin : g_bin
    logic [CNT_W-1:0] cntQ;
    logic             carryQ;
    logic             maskQ;
    logic [1:0]       inc;
    logic [CNT_W-1:0] base;
    logic [CNT_W:0]   sum;

    always_comb begin
      inc  = {1'b0, binStb[b].hitTx} + {1'b0, binStb[b].hitRx};
      base = binStb[b].rdClr ? '0 : cntQ;
      sum  = {1'b0, base} + (CNT_W + 1)'(inc);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ   <= '0;
        carryQ <= 1'b0;
        maskQ  <= 1'b0;
      end else begin
        if (clrAll) begin
          cntQ   <= '0;
          carryQ <= 1'b0;
        end else begin
          cntQ   <= sum[CNT_W-1:0];
          carryQ <= sum[CNT_W] | (carryQ & ~binStb[b].carryClr);
        end
        if (binStb[b].maskWe) maskQ <= binStb[b].maskVal;
      end
    end

    assign cntVec[b]   = cntQ;
    assign carryVec[b] = carryQ;
    assign maskVec[b]  = maskQ;
  end

  always_comb begin
    rdData = '0;
    for (int b = 0; b < NBIN; b++) begin
      if (rdAddr == ADDR_W'(b)) rdData = REG_W'(cntVec[b]) << PAD_W;
    end
    if (rdAddr == ADDR_W'(CARRY_ADDR)) rdData = REG_W'(carryVec);
    if (rdAddr == ADDR_W'(MASK_ADDR))  rdData = REG_W'(maskVec);
  end

  assign irq = |(carryVec & ~maskVec);

endmodule

// File: rtl/frame_size_stats.sv
module frame_size_stats
  import fss_pkg::*;
#(
  parameter int unsigned NBIN   = 2,
  parameter int unsigned CNT_W  = 22,
  parameter int unsigned REG_W  = 32,
  parameter int unsigned LEN_W  = 14,
  parameter int unsigned ADDR_W = $clog2(NBIN + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txDone,
  input  logic [LEN_W-1:0]  txLen,
  input  logic              rxDone,
  input  logic [LEN_W-1:0]  rxLen,
  input  logic              clrOnRd,
  input  logic              clrAll,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  output logic              irq
);

  binStrobe_t [NBIN-1:0]       binStb;
  logic [NBIN-1:0][CNT_W-1:0]  cntVec;
  logic [NBIN-1:0]             carryVec;
  logic [NBIN-1:0]             maskVec;

  fss_ctrl #(
    .NBIN(NBIN), .LEN_W(LEN_W), .ADDR_W(ADDR_W), .REG_W(REG_W)
  ) u_ctrl (
    .txDone(txDone), .txLen(txLen), .rxDone(rxDone), .rxLen(rxLen),
    .rdEn(rdEn), .rdAddr(rdAddr), .clrOnRd(clrOnRd),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .binStb(binStb)
  );

  fss_datapath #(
    .NBIN(NBIN), .CNT_W(CNT_W), .REG_W(REG_W), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .clrAll(clrAll), .binStb(binStb),
    .rdAddr(rdAddr), .rdData(rdData), .irq(irq),
    .cntVec(cntVec), .carryVec(carryVec), .maskVec(maskVec)
  );

endmodule

// File: rtl/fss_checker.sv
module fss_checker #(
  parameter int unsigned NBIN   = 2,
  parameter int unsigned CNT_W  = 22,
  parameter int unsigned REG_W  = 32,
  parameter int unsigned ADDR_W = 2
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       clrAll,
  input logic                       clrOnRd,
  input logic                       rdEn,
  input logic [ADDR_W-1:0]          rdAddr,
  input logic                       wrEn,
  input logic [ADDR_W-1:0]          wrAddr,
  input logic [REG_W-1:0]           wrData,
  input logic                       irq,
  input logic [NBIN-1:0][CNT_W-1:0] cntVec,
  input logic [NBIN-1:0]            carryVec,
  input logic [NBIN-1:0]            maskVec
);

  localparam int unsigned CARRY_ADDR = NBIN;
  localparam int unsigned MASK_ADDR  = NBIN + 1;
  localparam logic [CNT_W-1:0] NEAR_FULL = {{(CNT_W-1){1'b1}}, 1'b0};

  // R7: a global clear leaves every counter and flag at zero
  a_r7_global_clear: assert property (@(posedge clk) disable iff (!rstN)
    clrAll |=> (cntVec == '0 && carryVec == '0));

  // R9: irq only with some carry flag pending
  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (carryVec != '0));

  // R9: masks move only on a mask write
  a_r9_mask_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrAddr == ADDR_W'(MASK_ADDR)) |=> $stable(maskVec));

  for (genvar b = 0; b < NBIN; b++) begin : g_chk
    // R4: at most one transmit and one receive increment per cycle
    a_r4_step_bound: assert property (@(posedge clk) disable iff (!rstN)
      (!clrAll && !(rdEn && clrOnRd && rdAddr == ADDR_W'(b)))
      |=> (CNT_W'(cntVec[b] - $past(cntVec[b])) <= CNT_W'(2)));

    // R8: a flag stays set until cleared
    a_r8_carry_sticky: assert property (@(posedge clk) disable iff (!rstN)
      (carryVec[b] && !clrAll && !(wrEn && wrAddr == ADDR_W'(CARRY_ADDR) && wrData[b]))
      |=> carryVec[b]);

    // R8: a flag rises only out of a counter about to wrap
    a_r8_carry_origin: assert property (@(posedge clk) disable iff (!rstN)
      $rose(carryVec[b]) |-> ($past(cntVec[b]) >= NEAR_FULL));
  end

endmodule

bind frame_size_stats fss_checker #(
  .NBIN(NBIN), .CNT_W(CNT_W), .REG_W(REG_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .clrAll(clrAll), .clrOnRd(clrOnRd),
  .rdEn(rdEn), .rdAddr(rdAddr), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .irq(irq), .cntVec(cntVec), .carryVec(carryVec), .maskVec(maskVec)
);

// File: tb/sim_frame_size_stats.sv
module sim_frame_size_stats;

  localparam int CW   = 8;
  localparam int RW   = 32;
  localparam int LW   = 14;
  localparam int AW   = 2;
  localparam int WRAP = 1 << CW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          txDone = 1'b0, rxDone = 1'b0;
  logic [LW-1:0] txLen = '0, rxLen = '0;
  logic          clrOnRd = 1'b0, clrAll = 1'b0;
  logic          rdEn = 1'b0, wrEn = 1'b0;
  logic [AW-1:0] rdAddr = '0, wrAddr = '0;
  logic [RW-1:0] wrData = '0;
  logic [RW-1:0] rdData;
  logic          irq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  int       mCnt [2];
  bit [1:0] mCarry = 2'b00;
  bit [1:0] mMask  = 2'b00;

  frame_size_stats #(.NBIN(2), .CNT_W(CW), .REG_W(RW), .LEN_W(LW)) u0 (
    .clk(clk), .rstN(rstN), .txDone(txDone), .txLen(txLen), .rxDone(rxDone), .rxLen(rxLen),
    .clrOnRd(clrOnRd), .clrAll(clrAll), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic int binOf(int len);
    if (len == 64) return 0;
    if (len >= 65 && len <= 127) return 1;
    return -1;
  endfunction

  function automatic longint expRead(int ra);
    if (ra < 2) return longint'(mCnt[ra]) << (RW - CW);
    if (ra == 2) return longint'(mCarry);
    return longint'(mMask);
  endfunction

  task automatic chk(longint act, longint exp, string tag);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One clock cycle of stimulus; model updated from the requirements.
  task automatic cyc(bit tD, int tL, bit rD, int rL, bit rd, int ra,
                     bit wr, int wa, int wd, bit ca, string tag);
    @(negedge clk);
    txDone = tD; txLen = LW'(tL); rxDone = rD; rxLen = LW'(rL);
    rdEn = rd; rdAddr = AW'(ra); wrEn = wr; wrAddr = AW'(wa); wrData = RW'(wd);
    clrAll = ca;
    #1;
    if (rd) chk(longint'(rdData), expRead(ra), tag);
    for (int b = 0; b < 2; b++) begin
      int inc;
      int s;
      inc = ((tD && binOf(tL) == b) ? 1 : 0) + ((rD && binOf(rL) == b) ? 1 : 0);
      if (ca) begin
        mCnt[b] = 0;
        mCarry[b] = 1'b0;
      end else begin
        s = ((rd && clrOnRd && ra == b) ? 0 : mCnt[b]) + inc;
        mCarry[b] = (s >= WRAP) | (mCarry[b] & !(wr && wa == 2 && wd[b]));
        mCnt[b] = s % WRAP;
      end
    end
    if (wr && wa == 3) mMask = 2'(wd);
    @(posedge clk);
    #1;
    chk(longint'(irq), longint'(|(mCarry & ~mMask)), "R9 irq");
  endtask

  task automatic rdChk(int ra, string tag);
    cyc(0, 0, 0, 0, 1, ra, 0, 0, 0, 0, tag);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
  endtask

  function automatic int pickLen();
    case ($urandom % 7)
      0: return 63;
      1: return 64;
      2: return 65;
      3: return 127;
      4: return 128;
      default: return $urandom % 200;
    endcase
  endfunction

  initial begin
    mCnt[0] = 0; mCnt[1] = 0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(longint'(irq), 0, "R11 irq after reset");
    // R11: reset values of counters, carry and mask
    rdChk(0, "R11 cnt64"); rdChk(1, "R11 cnt127");
    rdChk(2, "R11 carry"); rdChk(3, "R11 mask");

    // R1: exact 64 from each side
    cyc(1, 64, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    cyc(0, 0, 1, 64, 0, 0, 0, 0, 0, 0, "R1");
    idle();
    // R5: field position
    chk(longint'(mCnt[0]), 2, "R1 model");
    rdChk(0, "R1 R5 cnt64");

    // R2: 65..127 edges and middle
    cyc(1, 65, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    cyc(0, 0, 1, 127, 0, 0, 0, 0, 0, 0, "R2");
    cyc(1, 100, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    idle();
    rdChk(1, "R2 cnt127");

    // R3: out-of-range lengths
    cyc(1, 63, 1, 128, 0, 0, 0, 0, 0, 0, "R3");
    cyc(1, 0, 1, 1518, 0, 0, 0, 0, 0, 0, "R3");
    idle();
    rdChk(0, "R3 cnt64"); rdChk(1, "R3 cnt127");

    // R4: both sides, same bin, same cycle
    cyc(1, 64, 1, 64, 0, 0, 0, 0, 0, 0, "R4");
    idle();
    rdChk(0, "R4 cnt64");

    // R10: writes to counter addresses ignored
    cyc(0, 0, 0, 0, 0, 0, 1, 0, -1, 0, "R10");
    cyc(0, 0, 0, 0, 0, 0, 1, 1, -1, 0, "R10");
    rdChk(0, "R10 cnt64"); rdChk(1, "R10 cnt127");

    // R6: clear-on-read with a same-cycle increment
    clrOnRd = 1'b1;
    cyc(1, 64, 0, 0, 1, 0, 0, 0, 0, 0, "R6 old value");
    clrOnRd = 1'b0;
    idle();
    chk(longint'(mCnt[0]), 1, "R6 model");
    rdChk(0, "R6 after clear");
    rdChk(0, "R6 no clear when disabled");

    // R8: wrap of bin 1 with paired increments
    for (int i = 0; i < WRAP / 2; i++) cyc(1, 90, 1, 90, 0, 0, 0, 0, 0, 0, "R8 wrap");
    chk(longint'(mCarry), 2, "R8 model");
    rdChk(2, "R8 carry set");
    // R9: masking
    cyc(0, 0, 0, 0, 0, 0, 1, 3, 2, 0, "R9 mask");
    rdChk(3, "R9 mask read");
    cyc(0, 0, 0, 0, 0, 0, 1, 3, 0, 0, "R9 unmask");
    // R8: write-one-to-clear
    cyc(0, 0, 0, 0, 0, 0, 1, 2, 2, 0, "R8 w1c");
    rdChk(2, "R8 carry cleared");

    // R8: wrap in the clear cycle keeps the flag
    while (mCnt[0] != WRAP - 1) cyc(1, 64, 0, 0, 0, 0, 0, 0, 0, 0, "R8 fill");
    cyc(1, 64, 0, 0, 0, 0, 1, 2, 1, 0, "R8 set wins");
    rdChk(2, "R8 set wins");

    // R7: global clear beats same-cycle increments
    cyc(1, 64, 1, 100, 0, 0, 0, 0, 0, 1, "R7");
    rdChk(0, "R7 cnt64"); rdChk(1, "R7 cnt127"); rdChk(2, "R7 carry");

    // Random traffic
    for (int i = 0; i < 6000; i++) begin
      bit rd, wr, ca;
      int wa;
      if ($urandom % 50 == 0) clrOnRd = ~clrOnRd;
      rd = ($urandom % 3) == 0;
      wr = ($urandom % 12) == 0;
      ca = ($urandom % 400) == 0;
      wa = 2 + ($urandom % 2);
      cyc($urandom % 2, pickLen(), $urandom % 2, pickLen(), rd, $urandom % 4,
          wr, wa, $urandom % 4, ca, "R5 R6 random read");
    end
    clrOnRd = 1'b0;
    rdChk(0, "R5 final"); rdChk(1, "R5 final");
    rdChk(2, "R8 final"); rdChk(3, "R9 final");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule